// File: doc/BRIEF.md
# Display output pixel formatter

This stage sits between a pixel source and the display output pins. Each clock it may accept one pixel of three 12-bit components, marked by a valid strobe. Alongside the pixel come horizontal and vertical sync sidebands and a line-start marker. The stage does not convert between colour spaces. It reorders and limits the data that reaches it. All controls are static inputs, and they are changed only while no pixels are flowing.

The data passes through four steps in this order:

1. An optional red/blue exchange on the input.
2. Range limiting of luma and chroma, applied only to YCbCr data.
3. A reorder of the three components into one of six channel orders.
4. An optional luma/chroma packing for 4:2:2 buses, followed by a reduction to the chosen output depth.

Two setups are common. For 4:2:2 output, turn on packing and the input exchange, and keep the plain RGB channel order. For 4:4:4 YCbCr output, turn packing off and use the reversed (BGR) order. Software normally programs every limit to the range 0x010 to 0xFE0.

Top module: `pix_fmt_top`

## Requirements
- R1: Pixel data, `vld_o`, `hs_o` and `vs_o` appear exactly two clock cycles after the matching inputs are sampled.
- R2: When `rb_swap_i` is 1, input components 0 and 2 are exchanged before any other step. `pix_i` is {c0,c1,c2}, with c0 in bits 35:24.
- R3: When `is_ycc_i` is 1, component 1 (luma) is limited to [`y_lo_i`,`y_hi_i`] and components 0 and 2 (chroma) to [`c_lo_i`,`c_hi_i`]. A value below the lower limit becomes the lower limit. Otherwise a value above the upper limit becomes the upper limit. The lower test takes precedence.
- R4: When `is_ycc_i` is 0, no limiting is applied.
- R5: `ord_i` selects the order of the output slots, from the components a0,a1,a2 after limiting. The codes are 0=RGB (a0,a1,a2), 1=GBR (a1,a2,a0), 2=BRG (a2,a0,a1), 3=RBG (a0,a2,a1), 4=GRB (a1,a0,a2) and 5=BGR (a2,a1,a0). Codes 6 and 7 act as RGB.
- R6: `yc_map_i` selects the bus mapping. Y is slot 1 and C is the chroma chosen by the phase. The codes are 0=passthrough, 1=CYCY (0,C,Y), 2=YCYC (0,Y,C), 3=CY (C,Y,0) and 4=YC (Y,C,0). Codes 5 to 7 act as passthrough.
- R7: The chroma phase selects slot 0 on even pixels and slot 2 on odd pixels. It advances only on valid pixels. A valid pixel with `sol_i` high is always even.
- R8: `depth_i` selects the depth of each 16-bit output lane, with the result in the low bits of the lane. Code 0 keeps 8 MSBs, 1 keeps 10 MSBs and 2 keeps all 12 bits. Code 3 gives 16 bits, the 12 bits followed by four zeros. Codes 4 to 7 act as code 0. `pix_o` is {lane0,lane1,lane2}, with lane0 in the MSBs.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input pixel valid |
| sol_i | input | 1 | First pixel of a line |
| hs_i | input | 1 | Horizontal sync sideband |
| vs_i | input | 1 | Vertical sync sideband |
| pix_i | input | 36 | Three 12-bit components {c0,c1,c2} |
| is_ycc_i | input | 1 | Data is YCbCr; enables limiting |
| rb_swap_i | input | 1 | Exchange components 0 and 2 on input |
| ord_i | input | 3 | Channel order code |
| yc_map_i | input | 3 | Luma/chroma bus mapping code |
| depth_i | input | 3 | Output depth code |
| y_lo_i | input | 12 | Luma lower limit |
| y_hi_i | input | 12 | Luma upper limit |
| c_lo_i | input | 12 | Chroma lower limit |
| c_hi_i | input | 12 | Chroma upper limit |
| vld_o | output | 1 | Output pixel valid |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| pix_o | output | 48 | Three 16-bit lanes {lane0,lane1,lane2} |

## Verification
Some properties are checked on every cycle:

- The valid strobe carries through both stages.
- Luma stays inside its limits when the order is RGB and the limits are ordered.
- A line-start pixel is even, and the phase flips between consecutive pixels of a line.
- The lanes that must be empty are zero in the CY/YC mappings and at 8-bit depth.

Only the bench's scenarios can show the rest. That covers the exact values of all six orders, the fallback codes, the precedence of the lower limit when the limits are inverted, and the chroma sequence across gaps and mid-line restarts. Those outcomes depend on the particular data and control combinations applied.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned LANE_W = 16;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_GBR = 3'd1;
  localparam logic [2:0] ORD_BRG = 3'd2;
  localparam logic [2:0] ORD_RBG = 3'd3;
  localparam logic [2:0] ORD_GRB = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;

  localparam logic [2:0] MAP_PASS = 3'd0;
  localparam logic [2:0] MAP_CYCY = 3'd1;
  localparam logic [2:0] MAP_YCYC = 3'd2;
  localparam logic [2:0] MAP_CY   = 3'd3;
  localparam logic [2:0] MAP_YC   = 3'd4;

  localparam logic [2:0] DEP_8  = 3'd0;
  localparam logic [2:0] DEP_10 = 3'd1;
  localparam logic [2:0] DEP_12 = 3'd2;
  localparam logic [2:0] DEP_16 = 3'd3;
endpackage

// File: rtl/pf_range_clamp.sv
module pf_range_clamp #(
  parameter int CW = 12
) (
  input  logic          en_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] d_i,
  output logic [CW-1:0] d_o
);
  always_comb begin
    d_o = d_i;
    if (en_i) begin
      if (d_i < lo_i)      d_o = lo_i;   // lower bound wins on inverted limits
      else if (d_i > hi_i) d_o = hi_i;
    end
  end
endmodule

// File: rtl/pf_front.sv
module pf_front #(
  parameter int CW = 12
) (
  input  logic [0:2][CW-1:0] c_i,
  input  logic               swap_i,
  input  logic               ycc_i,
  input  logic [2:0]         ord_i,
  input  logic [CW-1:0]      y_lo_i,
  input  logic [CW-1:0]      y_hi_i,
  input  logic [CW-1:0]      c_lo_i,
  input  logic [CW-1:0]      c_hi_i,
  output logic [0:2][CW-1:0] s_o
);
  import pf_pkg::*;

  logic [0:2][CW-1:0] sw;
  logic [0:2][CW-1:0] cl;

  assign sw = swap_i ? {c_i[2], c_i[1], c_i[0]} : c_i;

  for (genvar k = 0; k < 3; k++) begin : g_clamp
    localparam bit IS_LUMA = (k == 1);
    pf_range_clamp #(.CW(CW)) u_clamp (
      .en_i (ycc_i),
      .lo_i (IS_LUMA ? y_lo_i : c_lo_i),
      .hi_i (IS_LUMA ? y_hi_i : c_hi_i),
      .d_i  (sw[k]),
      .d_o  (cl[k])
    );
  end

  always_comb begin
    unique case (ord_i)
      ORD_GBR: s_o = {cl[1], cl[2], cl[0]};
      ORD_BRG: s_o = {cl[2], cl[0], cl[1]};
      ORD_RBG: s_o = {cl[0], cl[2], cl[1]};
      ORD_GRB: s_o = {cl[1], cl[0], cl[2]};
      ORD_BGR: s_o = {cl[2], cl[1], cl[0]};
      default: s_o = cl;
    endcase
  end
endmodule

// File: rtl/pf_yc_pack.sv
module pf_yc_pack #(
  parameter int CW = 12
) (
  input  logic [0:2][CW-1:0] s_i,
  input  logic               odd_i,
  input  logic [2:0]         map_i,
  output logic [0:2][CW-1:0] p_o
);
  import pf_pkg::*;

  logic [CW-1:0] y, c;
  assign y = s_i[1];
  assign c = odd_i ? s_i[2] : s_i[0];

  always_comb begin
    unique case (map_i)
      MAP_CYCY: p_o = {{CW{1'b0}}, c, y};
      MAP_YCYC: p_o = {{CW{1'b0}}, y, c};
      MAP_CY:   p_o = {c, y, {CW{1'b0}}};
      MAP_YC:   p_o = {y, c, {CW{1'b0}}};
      default:  p_o = s_i;
    endcase
  end
endmodule

// File: rtl/pf_depth_trunc.sv
module pf_depth_trunc #(
  parameter int CW = 12,
  parameter int LW = 16
) (
  input  logic [0:2][CW-1:0] d_i,
  input  logic [2:0]         dep_i,
  output logic [0:2][LW-1:0] d_o
);
  import pf_pkg::*;
  localparam int SH = LW - CW;

  for (genvar k = 0; k < 3; k++) begin : g_lane
    logic [LW-1:0] wide;
    assign wide = LW'(d_i[k]) << SH;   // MSB-align the component in the lane
    always_comb begin
      unique case (dep_i)
        DEP_10:  d_o[k] = LW'(wide[LW-1 -: 10]);
        DEP_12:  d_o[k] = LW'(wide[LW-1 -: 12]);
        DEP_16:  d_o[k] = wide;
        default: d_o[k] = LW'(wide[LW-1 -: 8]);
      endcase
    end
  end
endmodule

// File: rtl/pix_fmt_top.sv
module pix_fmt_top #(
  parameter int CW = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic                          sol_i,
  input  logic                          hs_i,
  input  logic                          vs_i,
  input  logic [3*CW-1:0]               pix_i,
  input  logic                          is_ycc_i,
  input  logic                          rb_swap_i,
  input  logic [2:0]                    ord_i,
  input  logic [2:0]                    yc_map_i,
  input  logic [2:0]                    depth_i,
  input  logic [CW-1:0]                 y_lo_i,
  input  logic [CW-1:0]                 y_hi_i,
  input  logic [CW-1:0]                 c_lo_i,
  input  logic [CW-1:0]                 c_hi_i,
  output logic                          vld_o,
  output logic                          hs_o,
  output logic                          vs_o,
  output logic [3*pf_pkg::LANE_W-1:0]   pix_o
);
  import pf_pkg::*;
  localparam int LW = LANE_W;

  logic [0:2][CW-1:0] in_c, fr_s, s1_slot, pk_s;
  logic [0:2][LW-1:0] dp_s, s2_q;
  logic s1_vld, s1_hs, s1_vs, s1_odd;
  logic odd_q, cur_odd;

  assign in_c = pix_i;

  pf_front #(.CW(CW)) u_front (
    .c_i    (in_c),
    .swap_i (rb_swap_i),
    .ycc_i  (is_ycc_i),
    .ord_i  (ord_i),
    .y_lo_i (y_lo_i),
    .y_hi_i (y_hi_i),
    .c_lo_i (c_lo_i),
    .c_hi_i (c_hi_i),
    .s_o    (fr_s)
  );

  assign cur_odd = sol_i ? 1'b0 : odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q   <= 1'b0;
      s1_slot <= '0;
      s1_vld  <= 1'b0;
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      s1_odd  <= 1'b0;
    end else begin
      if (vld_i) odd_q <= ~cur_odd;
      s1_slot <= fr_s;
      s1_vld  <= vld_i;
      s1_hs   <= hs_i;
      s1_vs   <= vs_i;
      s1_odd  <= cur_odd;
    end
  end

  pf_yc_pack #(.CW(CW)) u_pack (
    .s_i   (s1_slot),
    .odd_i (s1_odd),
    .map_i (yc_map_i),
    .p_o   (pk_s)
  );

  pf_depth_trunc #(.CW(CW), .LW(LW)) u_depth (
    .d_i   (pk_s),
    .dep_i (depth_i),
    .d_o   (dp_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_q  <= '0;
      vld_o <= 1'b0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
    end else begin
      s2_q  <= dp_s;
      vld_o <= s1_vld;
      hs_o  <= s1_hs;
      vs_o  <= s1_vs;
    end
  end

  assign pix_o = s2_q;

  p_vld_pipe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |=> vld_o);

  p_luma_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && is_ycc_i && ord_i == ORD_RGB && y_lo_i <= y_hi_i)
      |-> (s1_slot[1] >= y_lo_i && s1_slot[1] <= y_hi_i));

  p_sol_even_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sol_i) |=> !s1_odd);

  p_phase_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && vld_i && !sol_i) |=> (s1_odd != $past(s1_odd)));

  p_lane_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && (yc_map_i == MAP_CY || yc_map_i == MAP_YC)) |-> (s2_q[2] == '0));

  p_depth8_hi_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && (depth_i == DEP_8 || depth_i > DEP_16))
      |-> (s2_q[0][LW-1:8] == '0 && s2_q[1][LW-1:8] == '0 && s2_q[2][LW-1:8] == '0));
endmodule

// File: tb/sim_pix_fmt_top.sv
module sim_pix_fmt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, sol = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [35:0] pix = '0;
  logic ycc = 1'b0, swp = 1'b0;
  logic [2:0] ord = 3'd0, map = 3'd0, dep = 3'd2;
  logic [11:0] ylo = 12'h010, yhi = 12'hFE0, clo = 12'h010, chi = 12'hFE0;
  logic vld_o, hs_o, vs_o;
  logic [47:0] pix_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  pix_fmt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .sol_i(sol), .hs_i(hs), .vs_i(vs),
    .pix_i(pix), .is_ycc_i(ycc), .rb_swap_i(swp), .ord_i(ord), .yc_map_i(map),
    .depth_i(dep), .y_lo_i(ylo), .y_hi_i(yhi), .c_lo_i(clo), .c_hi_i(chi),
    .vld_o(vld_o), .hs_o(hs_o), .vs_o(vs_o), .pix_o(pix_o)
  );

  function automatic int lim(int x, int lo, int hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic logic [47:0] model(bit odd);
    int a[3], s[3], o[3], idx[3], t, y, c;
    logic [47:0] r;
    a[0] = int'(pix[35:24]); a[1] = int'(pix[23:12]); a[2] = int'(pix[11:0]);
    if (swp) begin t = a[0]; a[0] = a[2]; a[2] = t; end
    if (ycc) begin
      a[0] = lim(a[0], int'(clo), int'(chi));
      a[1] = lim(a[1], int'(ylo), int'(yhi));
      a[2] = lim(a[2], int'(clo), int'(chi));
    end
    case (ord)
      3'd1: idx = '{1, 2, 0};
      3'd2: idx = '{2, 0, 1};
      3'd3: idx = '{0, 2, 1};
      3'd4: idx = '{1, 0, 2};
      3'd5: idx = '{2, 1, 0};
      default: idx = '{0, 1, 2};
    endcase
    foreach (s[k]) s[k] = a[idx[k]];
    y = s[1];
    c = odd ? s[2] : s[0];
    case (map)
      3'd1: o = '{0, c, y};
      3'd2: o = '{0, y, c};
      3'd3: o = '{c, y, 0};
      3'd4: o = '{y, c, 0};
      default: o = s;
    endcase
    for (int k = 0; k < 3; k++) begin
      t = o[k] * 16;
      case (dep)
        3'd1: t = t / 64;
        3'd2: t = t / 16;
        3'd3: t = t;
        default: t = t / 256;
      endcase
      r[47-16*k -: 16] = 16'(t);
    end
    return r;
  endfunction

  // reference pipeline: e1 after one edge, e2 is what the outputs show
  logic [47:0] ed1, ed2;
  bit ev1, ev2, eh1, eh2, es1, es2, mph;
  string et1, et2;

  always @(posedge clk) begin
    bit cur;
    if (!rst_n) begin
      ev1 = 0; ev2 = 0; eh1 = 0; eh2 = 0; es1 = 0; es2 = 0; mph = 0;
      ed1 = '0; ed2 = '0; et1 = "R9"; et2 = "R9";
    end else begin
      ed2 = ed1; ev2 = ev1; eh2 = eh1; es2 = es1; et2 = et1;
      cur = sol ? 1'b0 : mph;
      if (vld) mph = ~cur;
      ed1 = model(cur); ev1 = vld; eh1 = hs; es1 = vs; et1 = tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (vld_o !== ev2 || hs_o !== eh2 || vs_o !== es2 || (ev2 && pix_o !== ed2)) begin
        failures++;
        $display("FAIL %s act vld=%b hs=%b vs=%b pix=%h exp vld=%b hs=%b vs=%b pix=%h",
                 et2, vld_o, hs_o, vs_o, pix_o, ev2, eh2, es2, ed2);
      end
    end
  end

  task automatic step(logic [35:0] p, bit v, bit s);
    @(negedge clk);
    pix = p; vld = v; sol = s; hs = 1'($urandom); vs = 1'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(36'($urandom), 1'b0, 1'b0);
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) step({4'($urandom), 32'($urandom)}, 1'b1, i == 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero during reset
    repeat (3) @(negedge clk);
    checks++;
    if (vld_o !== 1'b0 || hs_o !== 1'b0 || vs_o !== 1'b0 || pix_o !== '0) begin
      failures++;
      $display("FAIL R9 act vld=%b pix=%h exp vld=0 pix=0", vld_o, pix_o);
    end
    rst_n = 1'b1;

    tag = "R1"; burst(20); idle(3);                   // R1/R4: rgb passthrough, 12-bit
    tag = "R4";
    for (int i = 0; i < 8; i++) step(36'hFFF_000_FFF, 1'b1, 1'b0);
    idle(3);

    swp = 1; tag = "R2"; burst(16); idle(3);
    swp = 0;

    ycc = 1; tag = "R3"; burst(24);
    step(36'h000_000_000, 1, 0); step(36'hFFF_FFF_FFF, 1, 0);
    step(36'h010_FE0_010, 1, 0); step(36'h00F_FE1_FE1, 1, 0); idle(3);
    ylo = 12'h800; yhi = 12'h100; clo = 12'h900; chi = 12'h050; // inverted limits
    burst(16); step(36'hFFF_7FF_000, 1, 0); idle(3);
    ylo = 12'h010; yhi = 12'hFE0; clo = 12'h010; chi = 12'hFE0;

    tag = "R5";
    for (int o = 0; o < 8; o++) begin ord = 3'(o); burst(6); idle(3); end
    ord = 0;

    tag = "R6";
    for (int m = 0; m < 8; m++) begin map = 3'(m); burst(7); idle(3); end

    tag = "R7"; map = 3'd3; swp = 1;
    for (int i = 0; i < 30; i++)
      step(36'($urandom), 1'($urandom), (i % 9) == 4);
    idle(3);
    map = 3'd2;
    for (int i = 0; i < 20; i++) step(36'($urandom), 1'b1, i == 7 || i == 8);
    idle(3);
    map = 0; swp = 0; ycc = 0;

    tag = "R8";
    for (int d = 0; d < 8; d++) begin dep = 3'(d); burst(6); idle(3); end

    // 4:4:4 YCbCr setup: reversed order, no packing
    tag = "R5"; ycc = 1; ord = 3'd5; dep = 3'd3; burst(10); idle(3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule